// File: doc/BRIEF.md
# Supervisor Control Register File

This block keeps the supervisor control state of a small processor core: a 32-bit status word, the exception program counter, the faulting virtual address and the exception vector base. Move-to and move-from control-register requests select one of these registers with a 5-bit index. Reads are combinational. Writes take effect at the next rising clock edge. The block also exposes a read-only memory-size value, an inbound mailbox word from the host, and an outbound mailbox that the host sees as data plus a one-cycle valid strobe.

The status word sets the privilege level and the active general-register width. In 32-bit operation, every value read out is sign-extended from bit 31. Every value written in is sign-extended from bit 31 before it is stored. A trap request updates the status and exception PC in one cycle. If a trap arrives while exceptions are disabled, the block does not take it and sets a sticky error flag instead. Access from user mode is refused and flagged.

Top module: `ctrlreg_unit`

## Requirements
- R1: A read with index 0 returns status, 1 the exception PC, 2 the bad address, 3 the exception base, 8 the memory size in 4 KiB pages and 17 the inbound host word. Every other index, 16 included, reads as all ones.
- R2: A write with index 0, 1, 3 or 16 updates status, exception PC, exception base or the outbound mailbox. Writes to any other index change nothing.
- R3: Data written to the exception base is stored with bits 11:0 cleared.
- R4: The status bit positions are: bit 0 exception enable, bit 1 previous supervisor, bit 2 supervisor, bit 3 user-64, bit 4 kernel-64. The `wide_mode` output is 1 when the supervisor bit and the kernel-64 bit are both set, or when the supervisor bit is clear and the user-64 bit is set. Otherwise it is 0.
- R5: When `wide_mode` is 0, read data is sign-extended from bit 31, and write data is sign-extended from bit 31 before it is stored. When `wide_mode` is 1, all XLEN bits pass unchanged.
- R6: A status write stores bits 31:16 as 0. When 64-bit support is not configured, it also stores bits 3 and 4 as 0.
- R7: A trap taken with exception enable set does all of the following in one cycle:
  - clears exception enable;
  - copies the old supervisor bit into previous supervisor;
  - sets supervisor;
  - loads the exception PC from `trap_pc`;
  - loads the bad address from `trap_bad_addr` when `trap_bad_vld` is 1.
- R8: A trap that arrives with exception enable clear sets `err_mode`, which stays set until reset. The registers do not change.
- R9: After reset, status holds only supervisor, plus kernel-64 when 64-bit support is configured (0x14 with support, 0x04 without). The exception PC, bad address and exception base are 0, and `err_mode` and `host_out_vld` are 0.
- R10: A read or write while the supervisor bit is clear drives `priv_fault` high in the same cycle, and a write then changes no register.
- R11: A write to index 16 presents the stored data on `host_out` with `host_out_vld` high for exactly the following cycle.
- R12: When a trap request and a write arrive in the same cycle, the trap is handled and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Move-from request |
| acc_wr | input | 1 | Move-to request |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | XLEN | Write data |
| acc_rdata | output | XLEN | Read data (combinational) |
| priv_fault | output | 1 | Access attempted outside supervisor mode |
| trap_req | input | 1 | Trap entry request |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_bad_vld | input | 1 | Bad address accompanies the trap |
| trap_bad_addr | input | XLEN | Faulting virtual address |
| host_in | input | XLEN | Inbound host mailbox word |
| host_out | output | XLEN | Outbound host mailbox data |
| host_out_vld | output | 1 | One-cycle strobe for `host_out` |
| wide_mode | output | 1 | Active register width is 64 |
| err_mode | output | 1 | Sticky fatal-trap flag |

## Verification
The bound checker watches several rules on every clock:
- reserved status bits stay zero, and the exception base keeps its low twelve bits zero;
- each taken trap leaves the status bits in their trap-entry form;
- a fatal trap raises `err_mode`, and the flag holds once set;
- user-mode writes leave the registers stable;
- the outbound strobe matches a supervisor write to the mailbox.

Only the bench scenarios can show the end-to-end data behaviour: the read map, sign extension in each width mode, width selection after a privilege change, and the build without 64-bit support.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

  localparam int ST_EE  = 0;
  localparam int ST_PS  = 1;
  localparam int ST_SUP = 2;
  localparam int ST_U64 = 3;
  localparam int ST_K64 = 4;
  localparam int ST_W   = 32;

  localparam logic [ST_W-1:0] ST_RSVD = 32'hFFFF_0000;

  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] IX_STATUS   = 5'd0;
  localparam logic [IDX_W-1:0] IX_EPC      = 5'd1;
  localparam logic [IDX_W-1:0] IX_BADVA    = 5'd2;
  localparam logic [IDX_W-1:0] IX_EBASE    = 5'd3;
  localparam logic [IDX_W-1:0] IX_MEMPG    = 5'd8;
  localparam logic [IDX_W-1:0] IX_TOHOST   = 5'd16;
  localparam logic [IDX_W-1:0] IX_FROMHOST = 5'd17;

  localparam int PAGE_SHIFT = 12;

  // Status value after masking reserved and unsupported bits
  function automatic logic [ST_W-1:0] st_clean(input logic [ST_W-1:0] v,
                                               input logic wide_ok);
    logic [ST_W-1:0] r;
    r = v & ~ST_RSVD;
    if (!wide_ok) begin
      r[ST_U64] = 1'b0;
      r[ST_K64] = 1'b0;
    end
    return r;
  endfunction

  // Status value produced by trap entry
  function automatic logic [ST_W-1:0] st_trap(input logic [ST_W-1:0] s);
    logic [ST_W-1:0] r;
    r         = s;
    r[ST_EE]  = 1'b0;
    r[ST_PS]  = s[ST_SUP];
    r[ST_SUP] = 1'b1;
    return r;
  endfunction

  // Active register width selection
  function automatic logic st_wide(input logic [ST_W-1:0] s);
    return s[ST_SUP] ? s[ST_K64] : s[ST_U64];
  endfunction

endpackage

// File: rtl/ctrlreg_status.sv
module ctrlreg_status
  import ctrlreg_pkg::*;
#(
  parameter bit HAS_WIDE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_val,
  input  logic            trap_en,
  output logic [ST_W-1:0] status_q
);

  localparam logic [ST_W-1:0] ST_RESET =
    (ST_W'(1) << ST_SUP) | (HAS_WIDE ? (ST_W'(1) << ST_K64) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= ST_RESET;
    end else if (trap_en) begin
      status_q <= st_trap(status_q);
    end else if (wr_en) begin
      status_q <= st_clean(wr_val, HAS_WIDE);
    end
  end

endmodule

// File: rtl/ctrlreg_exc.sv
module ctrlreg_exc
  import ctrlreg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_en,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            trap_bad_vld,
  input  logic [XLEN-1:0] trap_bad_addr,
  input  logic            epc_wr,
  input  logic            ebase_wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badva_q,
  output logic [XLEN-1:0] ebase_q
);

  localparam logic [XLEN-1:0] EBASE_MASK = ~((XLEN'(1) << PAGE_SHIFT) - XLEN'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q <= '0;
    end else if (trap_en) begin
      epc_q <= trap_pc;
    end else if (epc_wr) begin
      epc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      badva_q <= '0;
    end else if (trap_en && trap_bad_vld) begin
      badva_q <= trap_bad_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ebase_q <= '0;
    end else if (ebase_wr) begin
      ebase_q <= wdata & EBASE_MASK;
    end
  end

endmodule

// File: rtl/ctrlreg_rdmux.sv
module ctrlreg_rdmux
  import ctrlreg_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter longint unsigned MEM_BYTES = 64'd268435456
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [ST_W-1:0]  status_q,
  input  logic [XLEN-1:0]  epc_q,
  input  logic [XLEN-1:0]  badva_q,
  input  logic [XLEN-1:0]  ebase_q,
  input  logic [XLEN-1:0]  host_in,
  input  logic             wide,
  output logic [XLEN-1:0]  rdata
);

  localparam logic [XLEN-1:0] MEM_PAGES = XLEN'(MEM_BYTES >> PAGE_SHIFT);

  function automatic logic [XLEN-1:0] sx32(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r = v;
    for (int i = 32; i < XLEN; i++) r[i] = v[31];
    return r;
  endfunction

  logic [XLEN-1:0] raw;

  always_comb begin
    unique case (idx)
      IX_STATUS:   raw = XLEN'(status_q);
      IX_EPC:      raw = epc_q;
      IX_BADVA:    raw = badva_q;
      IX_EBASE:    raw = ebase_q;
      IX_MEMPG:    raw = MEM_PAGES;
      IX_FROMHOST: raw = host_in;
      default:     raw = '1;
    endcase
  end

  assign rdata = wide ? raw : sx32(raw);

endmodule

// File: rtl/ctrlreg_host.sv
module ctrlreg_host #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            send,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] host_out,
  output logic            host_out_vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_out     <= '0;
      host_out_vld <= 1'b0;
    end else begin
      host_out_vld <= send;
      if (send) host_out <= wdata;
    end
  end

endmodule

// File: rtl/ctrlreg_unit.sv
module ctrlreg_unit
  import ctrlreg_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter bit              HAS_WIDE  = 1'b1,
  parameter longint unsigned MEM_BYTES = 64'd268435456
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [XLEN-1:0]  acc_wdata,
  output logic [XLEN-1:0]  acc_rdata,
  output logic             priv_fault,
  input  logic             trap_req,
  input  logic [XLEN-1:0]  trap_pc,
  input  logic             trap_bad_vld,
  input  logic [XLEN-1:0]  trap_bad_addr,
  input  logic [XLEN-1:0]  host_in,
  output logic [XLEN-1:0]  host_out,
  output logic             host_out_vld,
  output logic             wide_mode,
  output logic             err_mode
);

  function automatic logic [XLEN-1:0] sx32(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r = v;
    for (int i = 32; i < XLEN; i++) r[i] = v[31];
    return r;
  endfunction

  logic [ST_W-1:0] status_q;
  logic [XLEN-1:0] epc_q, badva_q, ebase_q;
  logic            sup;
  logic            wr_fire;
  logic            trap_take;
  logic            trap_fatal;
  logic [XLEN-1:0] wval;
  logic            err_q;

  assign sup        = status_q[ST_SUP];
  assign wide_mode  = st_wide(status_q);
  assign priv_fault = (acc_rd | acc_wr) & ~sup;
  assign trap_take  = trap_req & status_q[ST_EE];
  assign trap_fatal = trap_req & ~status_q[ST_EE];
  assign wr_fire    = acc_wr & sup & ~trap_req;
  assign wval       = wide_mode ? acc_wdata : sx32(acc_wdata);

  ctrlreg_status #(.HAS_WIDE(HAS_WIDE)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire && acc_idx == IX_STATUS),
    .wr_val  (wval[ST_W-1:0]),
    .trap_en (trap_take),
    .status_q(status_q)
  );

  ctrlreg_exc #(.XLEN(XLEN)) u_exc (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_en      (trap_take),
    .trap_pc      (trap_pc),
    .trap_bad_vld (trap_bad_vld),
    .trap_bad_addr(trap_bad_addr),
    .epc_wr       (wr_fire && acc_idx == IX_EPC),
    .ebase_wr     (wr_fire && acc_idx == IX_EBASE),
    .wdata        (wval),
    .epc_q        (epc_q),
    .badva_q      (badva_q),
    .ebase_q      (ebase_q)
  );

  ctrlreg_rdmux #(.XLEN(XLEN), .MEM_BYTES(MEM_BYTES)) u_rdmux (
    .idx     (acc_idx),
    .status_q(status_q),
    .epc_q   (epc_q),
    .badva_q (badva_q),
    .ebase_q (ebase_q),
    .host_in (host_in),
    .wide    (wide_mode),
    .rdata   (acc_rdata)
  );

  ctrlreg_host #(.XLEN(XLEN)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .send        (wr_fire && acc_idx == IX_TOHOST),
    .wdata       (wval),
    .host_out    (host_out),
    .host_out_vld(host_out_vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (trap_fatal) err_q <= 1'b1;
  end

  assign err_mode = err_q;

endmodule

// File: rtl/ctrlreg_unit_chk.sv
module ctrlreg_unit_chk
  import ctrlreg_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter bit HAS_WIDE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ST_W-1:0]  status_q,
  input logic [XLEN-1:0]  epc_q,
  input logic [XLEN-1:0]  ebase_q,
  input logic             trap_take,
  input logic             trap_fatal,
  input logic             trap_req,
  input logic             err_mode,
  input logic             wr_fire,
  input logic             acc_wr,
  input logic             priv_fault,
  input logic [IDX_W-1:0] acc_idx,
  input logic             host_out_vld
);

  // R3
  ebase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ebase_q[PAGE_SHIFT-1:0] == '0);

  // R6
  status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ST_RSVD) == '0);

  // R6
  narrow_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_WIDE |-> (status_q[ST_K64] == 1'b0 && status_q[ST_U64] == 1'b0));

  // R7
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (!status_q[ST_EE] && status_q[ST_SUP] &&
                   status_q[ST_PS] == $past(status_q[ST_SUP])));

  // R8
  fatal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fatal |=> err_mode);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode);

  // R8
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fatal |=> ($stable(status_q) && $stable(epc_q)));

  // R10
  priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_fault && acc_wr && !trap_req) |=>
      ($stable(status_q) && $stable(epc_q) && $stable(ebase_q)));

  // R11
  tohost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_idx == IX_TOHOST) |=> host_out_vld);

  // R11
  tohost_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_fire && acc_idx == IX_TOHOST)) |=> !host_out_vld);

endmodule

bind ctrlreg_unit ctrlreg_unit_chk #(.XLEN(XLEN), .HAS_WIDE(HAS_WIDE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_q    (status_q),
  .epc_q       (epc_q),
  .ebase_q     (ebase_q),
  .trap_take   (trap_take),
  .trap_fatal  (trap_fatal),
  .trap_req    (trap_req),
  .err_mode    (err_mode),
  .wr_fire     (wr_fire),
  .acc_wr      (acc_wr),
  .priv_fault  (priv_fault),
  .acc_idx     (acc_idx),
  .host_out_vld(host_out_vld)
);

// File: tb/ctrlreg_unit_bench.sv
module ctrlreg_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;
  localparam int NVEC       = 9;

  localparam logic [63:0] ONES    = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] HOST_IN = 64'hA5A5_0000_1111_2222;

  localparam logic [4:0] V_IDX [NVEC] = '{5'd1, 5'd3, 5'd2, 5'd8, 5'd17,
                                         5'd9, 5'd31, 5'd1, 5'd16};
  localparam logic [63:0] V_WR [NVEC] = '{
    64'h1234_5678_9ABC_DEF0, ONES, 64'h55, 64'h77, 64'h99,
    64'h5, 64'h0, 64'h0000_0000_8000_0000, 64'h0};
  localparam logic [63:0] V_EXP [NVEC] = '{
    64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_F000, 64'h0, 64'h10000, HOST_IN,
    ONES, ONES, 64'h0000_0000_8000_0000, ONES};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acc_rd = 1'b0, acc_wr = 1'b0;
  logic [4:0]      acc_idx = '0;
  logic [XLEN-1:0] acc_wdata = '0;
  logic [XLEN-1:0] acc_rdata;
  logic            priv_fault;
  logic            trap_req = 1'b0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            trap_bad_vld = 1'b0;
  logic [XLEN-1:0] trap_bad_addr = '0;
  logic [XLEN-1:0] host_in = HOST_IN;
  logic [XLEN-1:0] host_out;
  logic            host_out_vld, wide_mode, err_mode;

  logic            n_rd = 1'b0, n_wr = 1'b0;
  logic [XLEN-1:0] n_rdata, n_host_out;
  logic            n_fault, n_vld, n_wide, n_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrlreg_unit #(.XLEN(XLEN), .HAS_WIDE(1'b1)) u_ctrlreg_unit (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .priv_fault(priv_fault), .trap_req(trap_req), .trap_pc(trap_pc),
    .trap_bad_vld(trap_bad_vld), .trap_bad_addr(trap_bad_addr),
    .host_in(host_in), .host_out(host_out), .host_out_vld(host_out_vld),
    .wide_mode(wide_mode), .err_mode(err_mode));

  ctrlreg_unit #(.XLEN(XLEN), .HAS_WIDE(1'b0)) u_ctrlreg_unit_narrow (
    .clk(clk), .rst_n(rst_n), .acc_rd(n_rd), .acc_wr(n_wr),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(n_rdata),
    .priv_fault(n_fault), .trap_req(1'b0), .trap_pc('0),
    .trap_bad_vld(1'b0), .trap_bad_addr('0),
    .host_in(host_in), .host_out(n_host_out), .host_out_vld(n_vld),
    .wide_mode(n_wide), .err_mode(n_err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, output logic [63:0] d);
    @(negedge clk);
    acc_rd = 1'b1; acc_idx = idx;
    #1 d = acc_rdata;
    acc_rd = 1'b0;
  endtask

  task automatic nwr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    n_wr = 1'b1; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    n_wr = 1'b0;
  endtask

  task automatic nrd(input logic [4:0] idx, output logic [63:0] d);
    @(negedge clk);
    n_rd = 1'b1; acc_idx = idx;
    #1 d = n_rdata;
    n_rd = 1'b0;
  endtask

  task automatic trap(input logic [63:0] pc, input logic bv, input logic [63:0] ba);
    @(negedge clk);
    trap_req = 1'b1; trap_pc = pc; trap_bad_vld = bv; trap_bad_addr = ba;
    @(negedge clk);
    trap_req = 1'b0; trap_bad_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(5'd0, v); chk("R9 status", v, 64'h14);
    rd(5'd1, v); chk("R9 epc", v, 64'h0);
    rd(5'd2, v); chk("R9 badva", v, 64'h0);
    rd(5'd3, v); chk("R9 ebase", v, 64'h0);
    chk("R9 err_mode", {63'd0, err_mode}, 64'h0);
    chk("R9 host_out_vld", {63'd0, host_out_vld}, 64'h0);
    chk("R4 reset wide", {63'd0, wide_mode}, 64'h1);
    nrd(5'd0, v); chk("R9 narrow status", v, 64'h4);
    chk("R4 narrow wide", {63'd0, n_wide}, 64'h0);

    // R1 R2 R3 table walk in 64-bit mode
    for (int i = 0; i < NVEC; i++) begin
      wr(V_IDX[i], V_WR[i]);
      rd(V_IDX[i], v);
      chk($sformatf("R1/R2/R3 vec%0d", i), v, V_EXP[i]);
    end

    // R5 read sign extension in 32-bit mode
    wr(5'd1, 64'h0000_0001_8000_0000);
    wr(5'd0, 64'h04);
    chk("R4 sup without k64", {63'd0, wide_mode}, 64'h0);
    rd(5'd1, v); chk("R5 read sext", v, 64'hFFFF_FFFF_8000_0000);
    // R5 write sign extension
    wr(5'd1, 64'hABCD_0000_8000_0010);
    wr(5'd0, 64'h15);
    chk("R4 sup with k64", {63'd0, wide_mode}, 64'h1);
    rd(5'd1, v); chk("R5 write sext", v, 64'hFFFF_FFFF_8000_0010);

    // R6 reserved bits masked
    wr(5'd0, 64'hFFFF_0015);
    rd(5'd0, v); chk("R6 reserved", v, 64'h15);

    // R7 trap entry
    trap(64'h4000_0000_0000_0100, 1'b1, 64'hDEAD_BEEF_0000);
    rd(5'd0, v); chk("R7 status", v, 64'h16);
    rd(5'd1, v); chk("R7 epc", v, 64'h4000_0000_0000_0100);
    rd(5'd2, v); chk("R7 badva", v, 64'hDEAD_BEEF_0000);

    // R8 fatal trap with exceptions disabled
    trap(64'h200, 1'b1, 64'h1);
    chk("R8 err_mode", {63'd0, err_mode}, 64'h1);
    rd(5'd0, v); chk("R8 status kept", v, 64'h16);
    rd(5'd1, v); chk("R8 epc kept", v, 64'h4000_0000_0000_0100);
    rd(5'd2, v); chk("R8 badva kept", v, 64'hDEAD_BEEF_0000);

    // R10 user mode access refused
    wr(5'd0, 64'h11);
    chk("R4 user no u64", {63'd0, wide_mode}, 64'h0);
    @(negedge clk);
    acc_wr = 1'b1; acc_idx = 5'd0; acc_wdata = 64'h15;
    #1 chk("R10 fault flag", {63'd0, priv_fault}, 64'h1);
    @(negedge clk);
    acc_idx = 5'd3; acc_wdata = 64'h5000;
    @(negedge clk);
    acc_wr = 1'b0;
    trap(64'h300, 1'b0, 64'h0);
    rd(5'd0, v); chk("R10 status untouched", v, 64'h14);
    rd(5'd3, v); chk("R10 ebase untouched", v, 64'hFFFF_FFFF_FFFF_F000);

    // R4 user mode with u64
    wr(5'd0, 64'h19);
    chk("R4 user with u64", {63'd0, wide_mode}, 64'h1);
    trap(64'h400, 1'b0, 64'h0);
    rd(5'd0, v); chk("R7 from user", v, 64'h1C);

    // R12 trap wins over same-cycle write
    wr(5'd0, 64'h1D);
    @(negedge clk);
    trap_req = 1'b1; trap_pc = 64'h500;
    acc_wr = 1'b1; acc_idx = 5'd1; acc_wdata = 64'h999;
    @(negedge clk);
    trap_req = 1'b0; acc_wr = 1'b0;
    rd(5'd1, v); chk("R12 epc", v, 64'h500);
    rd(5'd0, v); chk("R12 status", v, 64'h1E);

    // R11 outbound mailbox strobe
    wr(5'd16, 64'h0123_4567_89AB_CDEF);
    chk("R11 vld", {63'd0, host_out_vld}, 64'h1);
    chk("R11 data", host_out, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    chk("R11 vld drop", {63'd0, host_out_vld}, 64'h0);

    // R6 R5 build without 64-bit support
    nwr(5'd0, 64'h1F);
    nrd(5'd0, v); chk("R6 narrow status", v, 64'h07);
    chk("R6 narrow wide", {63'd0, n_wide}, 64'h0);
    nwr(5'd1, 64'h0000_0000_8000_0004);
    nrd(5'd1, v); chk("R5 narrow epc", v, 64'hFFFF_FFFF_8000_0004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule